// File: doc/BRIEF.md
# Serial Accumulating Reduction Sequencer

This block runs the element loop of a reduce-mode vector instruction whose destination is a scalar. A plain vector loop would stop once a scalar destination had been written. Here the loop runs on, and every active element is folded into one scalar accumulator in strict program order. On each step the sequencer presents one element index and the current accumulator value to an external two-operand unit. It then waits for that unit's result and stores the result as the new accumulator before it moves to the next element.

A start pulse samples a 5-bit mode field, the vector length and a predicate mask. The sequencer acts only on the reduce encoding. Inside that encoding, one bit sets the direction of iteration: upward from element 0, or downward from the last element. The sibling encoding is reserved and is rejected with an illegal flag. Any other mode finishes at once with no work done. Elements whose predicate bit is clear are passed over, and the accumulator keeps its value.

Top module: `reduce_seq`

## Requirements
- R1: Mode bit k is `mode[k]`. Reduce is selected when `mode[0]`=0, `mode[1]`=0, `mode[2]`=1 and `mode[4]`=0; only then are element operations issued.
- R2: When `mode[1:0]`=00, `mode[2]`=1 and `mode[4]`=1, a start issues no operation, leaves `acc_out` unchanged, and raises `done` and `illegal` together one cycle after the start edge.
- R3: Any other non-reduce mode raises `done` one cycle after the start edge, with `illegal` low, no operations and `acc_out` unchanged.
- R4: With `mode[3]`=0, elements are visited in ascending index order, 0 to VL-1.
- R5: With `mode[3]`=1, elements are visited in descending index order, VL-1 to 0.
- R6: An element whose `pmask` bit is 0 gets no request and leaves the accumulator unchanged. The skip costs one cycle.
- R7: `op_req` stays high with stable `op_idx` and `op_acc` until `op_valid`. On that edge `op_res` becomes the accumulator, and no new request is raised before that response.
- R8: The first request carries `acc_init`. Each later request carries the previous result. `done` rises 2 + (skipped elements) + sum over active elements of (2 + response wait) cycles after the start edge, and at that point `acc_out` holds the final value.
- R9: VL=0, or a mask with no active element in range, finishes with `acc_out` = `acc_init` and no requests.
- R10: A start pulse while `busy` is high is ignored.
- R11: A VL above MAXVL is treated as MAXVL.
- R12: After reset, `busy`, `done`, `illegal`, `op_req` and `acc_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a loop, sampled when idle |
| mode | input | 5 | Mode field, bit k at index k |
| vl | input | $clog2(MAXVL+1) | Vector length |
| pmask | input | MAXVL | Predicate mask, bit i enables element i |
| acc_init | input | W | Initial scalar accumulator |
| op_req | output | 1 | Operation request to the external unit |
| op_idx | output | $clog2(MAXVL) | Element index of the request |
| op_acc | output | W | Accumulator operand of the request |
| op_valid | input | 1 | External result is valid |
| op_res | input | W | External result |
| acc_out | output | W | Current scalar accumulator |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Reserved mode was rejected |

## Verification
Non-reduce and reserved starts must show `done` one cycle after the start edge. A reduce loop must show `done` after the cycle count given in R8, which the bench works out in advance from the mask, the direction and the response delay it uses. The bench counts falling edges from the start and compares the count against that figure. Each request is checked against a queue of expected index and accumulator pairs on the first falling edge where it is visible. The response then goes back a fixed number of falling edges later, which fixes the cycle budget.

// File: rtl/reduce_seq.sv
module reduce_seq #(
  parameter int W     = 16,
  parameter int MAXVL = 8,
  localparam int IW   = $clog2(MAXVL),
  localparam int VW   = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [4:0]       mode,
  input  logic [VW-1:0]    vl,
  input  logic [MAXVL-1:0] pmask,
  input  logic [W-1:0]     acc_init,
  output logic             op_req,
  output logic [IW-1:0]    op_idx,
  output logic [W-1:0]     op_acc,
  input  logic             op_valid,
  input  logic [W-1:0]     op_res,
  output logic [W-1:0]     acc_out,
  output logic             busy,
  output logic             done,
  output logic             illegal
);

  typedef enum logic [1:0] {S_IDLE, S_STEP, S_WAIT} st_t;

  st_t              st;
  logic [W-1:0]     acc;
  logic [IW-1:0]    idx;
  logic [VW-1:0]    rem;
  logic [VW-1:0]    vl_q;
  logic [MAXVL-1:0] mask_q;
  logic             rg_q;
  logic             done_q, ill_q;

  wire is_red = (mode[1:0] == 2'b00) && mode[2] && !mode[4];
  wire is_rsv = (mode[1:0] == 2'b00) && mode[2] &&  mode[4];
  wire [VW-1:0] vl_eff = (vl > VW'(MAXVL)) ? VW'(MAXVL) : vl;
  wire [IW-1:0] idx_nxt = rg_q ? idx - IW'(1) : idx + IW'(1);

  assign op_req  = (st == S_WAIT);
  assign op_idx  = idx;
  assign op_acc  = acc;
  assign acc_out = acc;
  assign busy    = (st != S_IDLE);
  assign done    = done_q;
  assign illegal = ill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      acc    <= '0;
      idx    <= '0;
      rem    <= '0;
      vl_q   <= '0;
      mask_q <= '0;
      rg_q   <= 1'b0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (is_red) begin
            acc    <= acc_init;
            idx    <= mode[3] ? IW'(vl_eff - VW'(1)) : '0;
            rem    <= vl_eff;
            vl_q   <= vl_eff;
            mask_q <= pmask;
            rg_q   <= mode[3];
            st     <= S_STEP;
          end else begin
            done_q <= 1'b1;
            ill_q  <= is_rsv;
          end
        end
        S_STEP: begin
          if (rem == '0) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else if (mask_q[idx]) begin
            st <= S_WAIT;
          end else begin
            idx <= idx_nxt;
            rem <= rem - VW'(1);
          end
        end
        S_WAIT: if (op_valid) begin
          acc <= op_res;
          idx <= idx_nxt;
          rem <= rem - VW'(1);
          st  <= S_STEP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_illegal_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);

  a_r2_reserved_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && is_rsv) |=> (illegal && done && !busy && !op_req));

  a_r6_acc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(op_req && op_valid)) |=> $stable(acc_out));

  a_r7_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req && !op_valid) |=> (op_req && $stable(op_idx) && $stable(op_acc)));

  a_r11_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    op_req |-> (VW'(op_idx) < vl_q));

  a_r6_req_only_active: assert property (@(posedge clk) disable iff (!rst_n)
    op_req |-> mask_q[op_idx]);

endmodule

// File: tb/tb_reduce_seq.sv
`timescale 1ns/1ps
module tb_reduce_seq;
  localparam int W = 16, MAXVL = 8;
  localparam int IW = $clog2(MAXVL), VW = $clog2(MAXVL + 1);

  logic clk = 0, rst_n = 0, start = 0;
  logic [4:0] mode = '0;
  logic [VW-1:0] vl = '0;
  logic [MAXVL-1:0] pmask = '0;
  logic [W-1:0] acc_init = '0;
  logic op_req, op_valid = 0;
  logic [IW-1:0] op_idx;
  logic [W-1:0] op_acc, op_res = '0, acc_out;
  logic busy, done, illegal;

  reduce_seq #(.W(W), .MAXVL(MAXVL)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .vl(vl),
    .pmask(pmask), .acc_init(acc_init), .op_req(op_req), .op_idx(op_idx),
    .op_acc(op_acc), .op_valid(op_valid), .op_res(op_res), .acc_out(acc_out),
    .busy(busy), .done(done), .illegal(illegal));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  int exp_idx[$];
  int exp_acc[$];
  int rsp_delay = 0;
  bit seen = 0;
  int dcnt = 0;
  logic [W-1:0] cur_acc;
  logic [W-1:0] prev_acc = '0;

  function automatic logic [W-1:0] elem(int i);
    return W'(16'h1357 * (i + 1));
  endfunction

  function automatic logic [W-1:0] fop(logic [W-1:0] a, logic [W-1:0] e);
    return {a[W-2:0], a[W-1]} ^ e;
  endfunction

  task automatic chk(string tag, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // monitor and responder of the external operation unit
  always @(negedge clk) begin
    op_valid = 0;
    if (rst_n && op_req) begin
      if (!seen) begin
        seen = 1;
        dcnt = rsp_delay;
        if (exp_idx.size() == 0) begin
          chk("R7 unexpected request", 1, 0);
          cur_acc = op_acc;
        end else begin
          chk("R4/R5 order idx (R7)", int'(op_idx), exp_idx.pop_front());
          cur_acc = W'(exp_acc.pop_front());
          chk("R8 chained acc (R7)", int'(op_acc), int'(cur_acc));
        end
      end
      if (dcnt == 0) begin
        op_valid = 1;
        op_res = fop(cur_acc, elem(int'(op_idx)));
      end else dcnt--;
    end else seen = 0;
  end

  task automatic run(string tag, logic [4:0] m, int vlen, logic [MAXVL-1:0] mk,
                     logic [W-1:0] init, int dly, bit poke);
    int veff, cyc, ecyc, i;
    logic [W-1:0] a;
    bit red, rsv;
    red = (m[1:0] == 0) && m[2] && !m[4];
    rsv = (m[1:0] == 0) && m[2] && m[4];
    veff = (vlen > MAXVL) ? MAXVL : vlen;
    rsp_delay = dly;
    if (red) begin
      a = init;
      ecyc = 2;
      for (int k = 0; k < veff; k++) begin
        i = m[3] ? veff - 1 - k : k;
        if (mk[i]) begin
          exp_idx.push_back(i);
          exp_acc.push_back(int'(a));
          a = fop(a, elem(i));
          ecyc += 2 + dly;
        end else ecyc += 1;
      end
    end else begin
      a = prev_acc;
      ecyc = 1;
    end
    @(negedge clk);
    mode = m; vl = VW'(vlen); pmask = mk; acc_init = init; start = 1;
    @(negedge clk);
    start = 0;
    cyc = 1;
    while (!done && cyc < 400) begin
      if (poke && cyc == 3) begin
        start = 1; mode = 5'b00100; vl = VW'(1); pmask = '1; acc_init = 16'hdead;
      end else start = 0;
      @(negedge clk);
      cyc++;
    end
    start = 0;
    chk({tag, " done seen"}, int'(done), 1);
    chk({tag, " done cycle R8"}, cyc, ecyc);
    chk({tag, " acc_out R8"}, int'(acc_out), int'(a));
    chk({tag, " illegal R2"}, int'(illegal), int'(rsv));
    chk({tag, " all requests made R7"}, exp_idx.size(), 0);
    exp_idx.delete();
    exp_acc.delete();
    prev_acc = a;
    @(negedge clk);
    chk({tag, " done is a pulse R8"}, int'(done), 0);
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 busy", int'(busy), 0);
    chk("R12 done", int'(done), 0);
    chk("R12 illegal", int'(illegal), 0);
    chk("R12 op_req", int'(op_req), 0);
    chk("R12 acc_out", int'(acc_out), 0);
    rst_n = 1;
    run("R1 R4 forward full",      5'b00100, 8, 8'hff, 16'h0001, 0, 0);
    run("R5 reverse full",         5'b01100, 8, 8'hff, 16'h00a5, 1, 0);
    run("R6 forward masked",       5'b00100, 5, 8'b1011_0110, 16'h4242, 2, 0);
    run("R5 R6 reverse masked",    5'b01100, 6, 8'b0101_1010, 16'h7001, 0, 0);
    run("R9 vl zero",              5'b00100, 0, 8'hff, 16'h1234, 0, 0);
    run("R9 empty mask",           5'b01100, 8, 8'h00, 16'h5678, 0, 0);
    run("R2 reserved",             5'b10100, 8, 8'hff, 16'hbeef, 0, 0);
    run("R2 reserved reversed",    5'b11100, 4, 8'hff, 16'hbeef, 0, 0);
    run("R3 simple",               5'b00000, 8, 8'hff, 16'hcafe, 0, 0);
    run("R3 saturate",             5'b00101, 8, 8'hff, 16'hcafe, 0, 0);
    run("R11 vl clamp",            5'b00100, 12, 8'hff, 16'h0f0f, 0, 0);
    run("R11 vl clamp reverse",    5'b01100, 15, 8'b1100_0011, 16'h0ff0, 1, 0);
    run("R10 start while busy",    5'b01100, 8, 8'hff, 16'h3c3c, 2, 1);
    run("R1 after busy start",     5'b00100, 3, 8'h07, 16'h0002, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule